// File: doc/BRIEF.md
# Counter-Rotating Ring Transfer Controller

This block is the central controller and datapath of an on-chip ring interconnect that joins a small set of nodes. Several rings of equal data width run around the nodes. Rings with an even index move data from node k to node k+1, and rings with an odd index move data from node k to node k-1, so neighbouring rings turn in opposite directions. Each node has one link register per ring on its outgoing side. A beat therefore advances one node per clock, and its delay grows with the distance it travels.

A node asks for a transfer through a valid/ready port that carries the destination and the beat count. The controller picks the direction with fewer hops and then a ring in that direction whose links along the path are all free. It reserves those links and answers with a grant pulse that carries the ring index. The source then streams its beats, one per cycle. Transfers whose paths do not overlap can share a ring. The reservation is dropped after the last beat has passed the destination's buffer. A new node only adds hop latency.

Top module: `ring_fabric_ctl`

## Requirements
- R1: While reset is asserted and directly after it, with no request pending, req_ready, gnt_valid, tx_pull and rx_valid are all zero.
- R2: At most one request is accepted per cycle, and req_ready of a node is high only while that node's req_valid is high.
- R3: When several feasible requests are pending, the lowest index after the last accepted node (wrapping) is accepted. After reset the last accepted node counts as NODES-1, so node 0 has first priority.
- R4: Even ring indices move data from node k to k+1 and odd ones from k to k-1 (modulo NODES). The preferred direction is the one with fewer hops, and a tie goes to the even direction. The lowest-indexed free ring of the preferred direction is chosen, otherwise the lowest-indexed free ring of the opposite direction.
- R5: Link k of a ring is the register leaving node k. A transfer of h hops reserves the h links on its path, and a ring qualifies only if none of them is already reserved.
- R6: A request accepted in cycle c gives gnt_valid of the source in cycle c+1 with the ring index on gnt_ring. tx_pull of the source is high in cycles c+1 to c+beats, and tx_data is taken in each of those cycles.
- R7: A beat taken in cycle p shows up on rx_valid/rx_data at index ring*NODES+dst in cycle p+h+1. rx_last marks the final beat, and rx_valid is low in the cycles just before the first beat and just after the last.
- R8: Links reserved by a transfer become usable again in the cycle after the one in which its rx_last is shown. A request blocked only by them is accepted in that cycle.
- R9: A request with beats equal to zero, a request with destination equal to its source, and a request from a node that is still streaming are never accepted.
- R10: Two transfers whose link sets are disjoint run on the same ring at the same time without corrupting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NODES | Per-node transfer request |
| req_ready | output | NODES | Request accepted this cycle |
| req_dst | input | NODES*NODE_W | Destination node per requester |
| req_beats | input | NODES*BEAT_W | Beat count per requester |
| gnt_valid | output | NODES | Grant pulse, one cycle after acceptance |
| gnt_ring | output | NODES*RING_W | Ring index given with the grant |
| tx_pull | output | NODES | Source beat taken this cycle |
| tx_data | input | NODES*DATA_W | Source beat data per node |
| rx_valid | output | RINGS*NODES | Beat delivered at ring*NODES+node |
| rx_data | output | RINGS*NODES*DATA_W | Delivered beat data |
| rx_last | output | RINGS*NODES | Delivered beat is the final one |

## Verification
The bench builds the block with eight nodes, four rings, 32-bit beats and a 4-bit beat count. With that setup the tie at four hops, the single-hop counter-clockwise path and a seven-hop fallback path can all be reached. Two rings per direction are enough to block every ring for one request at once, so the exact release cycle can be observed. The 32-bit data word carries the source number and the cycle it was taken, so every delivered beat shows its own origin and its latency.

// File: rtl/ring_fabric_pkg.sv
package ring_fabric_pkg;

  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;

  // even rings turn towards higher node numbers, odd rings the other way
  function automatic ring_dir_e dir_of(input int ring);
    return (ring % 2 == 1) ? DIR_CCW : DIR_CW;
  endfunction

endpackage

// File: rtl/ring_path_sel.sv
module ring_path_sel
  import ring_fabric_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int RINGS  = 4,
  parameter int NODE_W = 3,
  parameter int RING_W = 2
) (
  input  logic [NODE_W-1:0]      src,
  input  logic [NODE_W-1:0]      dst,
  input  logic [RINGS*NODES-1:0] busy,
  output logic                   ok,
  output logic [RING_W-1:0]      ring_idx,
  output logic [NODES-1:0]       path
);

  int              hops_cw;
  int              hops_ccw;
  logic [NODES-1:0] m_cw;
  logic [NODES-1:0] m_ccw;
  logic [NODES-1:0] m_try;
  logic            want_ccw;
  logic            dir_try;

  always_comb begin
    hops_cw = int'(dst) - int'(src);
    if (hops_cw < 0) hops_cw = hops_cw + NODES;
    hops_ccw = (hops_cw == 0) ? 0 : NODES - hops_cw;
    m_cw  = '0;
    m_ccw = '0;
    for (int k = 0; k < NODES; k++) begin
      if (k < hops_cw)  m_cw[(int'(src) + k) % NODES] = 1'b1;
      if (k < hops_ccw) m_ccw[(int'(src) - k + NODES) % NODES] = 1'b1;
    end
    want_ccw = (hops_ccw < hops_cw);
    ok       = 1'b0;
    ring_idx = '0;
    path     = '0;
    dir_try  = 1'b0;
    m_try    = '0;
    for (int pass = 0; pass < 2; pass++) begin
      dir_try = (pass == 0) ? want_ccw : !want_ccw;
      m_try   = dir_try ? m_ccw : m_cw;
      for (int r = 0; r < RINGS; r++) begin
        if (!ok && hops_cw != 0 &&
            (dir_of(r) == (dir_try ? DIR_CCW : DIR_CW)) &&
            ((busy[r*NODES +: NODES] & m_try) == '0)) begin
          ok       = 1'b1;
          ring_idx = RING_W'(r);
          path     = m_try;
        end
      end
    end
  end

endmodule

// File: rtl/ring_rr_arb.sv
module ring_rr_arb #(
  parameter int NODES  = 8,
  parameter int NODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODES-1:0]  cand,
  output logic              sel_valid,
  output logic [NODE_W-1:0] sel
);

  logic [NODE_W-1:0] last_q;
  logic [NODE_W-1:0] last_d;
  int                idx;

  always_comb begin
    sel_valid = 1'b0;
    sel       = '0;
    idx       = 0;
    for (int k = 1; k <= NODES; k++) begin
      idx = (int'(last_q) + k) % NODES;
      if (!sel_valid && cand[idx]) begin
        sel_valid = 1'b1;
        sel       = NODE_W'(idx);
      end
    end
    last_d = sel_valid ? sel : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= NODE_W'(NODES - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/ring_lane.sv
module ring_lane
  import ring_fabric_pkg::*;
#(
  parameter int        NODES  = 8,
  parameter int        DATA_W = 128,
  parameter int        NODE_W = 3,
  parameter ring_dir_e DIR    = DIR_CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES-1:0]        inj_valid,
  input  logic [NODES-1:0]        inj_last,
  input  logic [NODES*NODE_W-1:0] inj_dst,
  input  logic [NODES*DATA_W-1:0] inj_data,
  output logic [NODES-1:0]        rx_valid,
  output logic [NODES-1:0]        rx_last,
  output logic [NODES*DATA_W-1:0] rx_data
);

  logic [NODES-1:0]  st_v_q, st_v_d, st_last_q, st_last_d;
  logic [NODE_W-1:0] st_dst_q [NODES];
  logic [NODE_W-1:0] st_dst_d [NODES];
  logic [DATA_W-1:0] st_data_q [NODES];
  logic [DATA_W-1:0] st_data_d [NODES];
  logic [NODES-1:0]  rx_v_d, rx_l_d;
  logic [DATA_W-1:0] rx_data_d [NODES];
  logic [DATA_W-1:0] rx_data_q [NODES];

  for (genvar k = 0; k < NODES; k++) begin : g_hop
    localparam int UP = (DIR == DIR_CW) ? (k + NODES - 1) % NODES : (k + 1) % NODES;
    logic arrive, drop_here;
    assign arrive    = st_v_q[UP];
    assign drop_here = arrive && (st_dst_q[UP] == NODE_W'(k));

    always_comb begin
      st_v_d[k]    = inj_valid[k] || (arrive && !drop_here);
      st_last_d[k] = inj_valid[k] ? inj_last[k] : st_last_q[UP];
      st_dst_d[k]  = inj_valid[k] ? inj_dst[k*NODE_W +: NODE_W] : st_dst_q[UP];
      st_data_d[k] = inj_valid[k] ? inj_data[k*DATA_W +: DATA_W] : st_data_q[UP];
      rx_v_d[k]    = drop_here;
      rx_l_d[k]    = drop_here && st_last_q[UP];
      rx_data_d[k] = st_data_q[UP];
    end

    assign rx_data[k*DATA_W +: DATA_W] = rx_data_q[k];

    // a passing beat and a fresh injection must never meet on one link
    AST_LINK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(inj_valid[k] && arrive && !drop_here)); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v_q    <= '0;
      st_last_q <= '0;
      rx_valid  <= '0;
      rx_last   <= '0;
    end else begin
      st_v_q    <= st_v_d;
      st_last_q <= st_last_d;
      rx_valid  <= rx_v_d;
      rx_last   <= rx_l_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NODES; k++) begin
      if (st_v_d[k]) begin
        st_dst_q[k]  <= st_dst_d[k];
        st_data_q[k] <= st_data_d[k];
      end
      if (rx_v_d[k]) rx_data_q[k] <= rx_data_d[k];
    end
  end

endmodule

// File: rtl/ring_fabric_ctl.sv
module ring_fabric_ctl
  import ring_fabric_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int RINGS  = 4,
  parameter int DATA_W = 128,
  parameter int BEAT_W = 4,
  parameter int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  parameter int RING_W = (RINGS > 1) ? $clog2(RINGS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NODES-1:0]              req_valid,
  output logic [NODES-1:0]              req_ready,
  input  logic [NODES*NODE_W-1:0]       req_dst,
  input  logic [NODES*BEAT_W-1:0]       req_beats,
  output logic [NODES-1:0]              gnt_valid,
  output logic [NODES*RING_W-1:0]       gnt_ring,
  output logic [NODES-1:0]              tx_pull,
  input  logic [NODES*DATA_W-1:0]       tx_data,
  output logic [RINGS*NODES-1:0]        rx_valid,
  output logic [RINGS*NODES*DATA_W-1:0] rx_data,
  output logic [RINGS*NODES-1:0]        rx_last
);

  logic [RINGS-1:0][NODES-1:0] busy_q, busy_d, rel;
  logic [RINGS*NODES-1:0]      busy_flat;
  logic [NODES-1:0]            own_q [RINGS][NODES];
  logic [NODES-1:0]            own_d [RINGS][NODES];

  logic [BEAT_W-1:0] left_q  [NODES];
  logic [BEAT_W-1:0] left_d  [NODES];
  logic [RING_W-1:0] sring_q [NODES];
  logic [RING_W-1:0] sring_d [NODES];
  logic [NODE_W-1:0] sdst_q  [NODES];
  logic [NODE_W-1:0] sdst_d  [NODES];
  logic [RING_W-1:0] gring_q [NODES];
  logic [RING_W-1:0] gring_d [NODES];
  logic [NODES-1:0]  gnt_d;

  logic [NODES-1:0]  path_ok, cand, take;
  logic [RING_W-1:0] pring [NODES];
  logic [NODES-1:0]  pmask [NODES];
  logic              sel_v;
  logic [NODE_W-1:0] sel;
  logic [RING_W-1:0] g_ring;
  logic [NODE_W-1:0] g_dst;
  logic [NODES-1:0]  g_mask;

  assign busy_flat = busy_q;

  // ---------------- request intake and route choice ----------------
  for (genvar n = 0; n < NODES; n++) begin : g_node
    ring_path_sel #(
      .NODES(NODES), .RINGS(RINGS), .NODE_W(NODE_W), .RING_W(RING_W)
    ) i_path (
      .src      (NODE_W'(n)),
      .dst      (req_dst[n*NODE_W +: NODE_W]),
      .busy     (busy_flat),
      .ok       (path_ok[n]),
      .ring_idx (pring[n]),
      .path     (pmask[n])
    );
    assign cand[n]    = req_valid[n] && path_ok[n] && (left_q[n] == '0) &&
                        (req_beats[n*BEAT_W +: BEAT_W] != '0);
    assign take[n]    = sel_v && (sel == NODE_W'(n));
    assign tx_pull[n] = (left_q[n] != '0);
    assign gnt_ring[n*RING_W +: RING_W] = gring_q[n];

    AST_GNT_STARTS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[n] |-> tx_pull[n]); // R6
    AST_PULL_HOLDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pull[n] |-> busy_q[sring_q[n]][n]); // R5
    AST_NO_EMPTY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[n] |-> ((req_beats[n*BEAT_W +: BEAT_W] != '0) &&
                        (req_dst[n*NODE_W +: NODE_W] != NODE_W'(n)))); // R9
  end

  ring_rr_arb #(.NODES(NODES), .NODE_W(NODE_W)) i_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand),
    .sel_valid (sel_v),
    .sel       (sel)
  );

  assign req_ready = take;

  // ---------------- reservation state ----------------
  always_comb begin
    g_ring = '0;
    g_dst  = '0;
    g_mask = '0;
    for (int n = 0; n < NODES; n++) begin
      if (take[n]) begin
        g_ring = pring[n];
        g_dst  = req_dst[n*NODE_W +: NODE_W];
        g_mask = pmask[n];
      end
    end
    rel = '0;
    for (int r = 0; r < RINGS; r++)
      for (int d = 0; d < NODES; d++)
        if (rx_valid[r*NODES+d] && rx_last[r*NODES+d]) rel[r] = rel[r] | own_q[r][d];
    busy_d = busy_q & ~rel;
    own_d  = own_q;
    if (sel_v) begin
      busy_d[g_ring]       = busy_d[g_ring] | g_mask;
      own_d[g_ring][g_dst] = g_mask;
    end
  end

  // ---------------- per-source beat streaming ----------------
  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      left_d[n]  = (left_q[n] != '0) ? left_q[n] - 1'b1 : left_q[n];
      sring_d[n] = sring_q[n];
      sdst_d[n]  = sdst_q[n];
      gring_d[n] = gring_q[n];
      gnt_d[n]   = take[n];
      if (take[n]) begin
        left_d[n]  = req_beats[n*BEAT_W +: BEAT_W];
        sring_d[n] = g_ring;
        sdst_d[n]  = g_dst;
        gring_d[n] = g_ring;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= '0;
      gnt_valid <= '0;
      for (int n = 0; n < NODES; n++) left_q[n] <= '0;
    end else begin
      busy_q    <= busy_d;
      gnt_valid <= gnt_d;
      for (int n = 0; n < NODES; n++) left_q[n] <= left_d[n];
    end
  end

  always_ff @(posedge clk) begin
    if (sel_v) own_q <= own_d;
    for (int n = 0; n < NODES; n++) begin
      if (take[n]) begin
        sring_q[n] <= sring_d[n];
        sdst_q[n]  <= sdst_d[n];
        gring_q[n] <= gring_d[n];
      end
    end
  end

  // ---------------- ring datapath ----------------
  for (genvar r = 0; r < RINGS; r++) begin : g_ring_lane
    logic [NODES-1:0]        inj_v, inj_l;
    logic [NODES*NODE_W-1:0] inj_dst;
    for (genvar n = 0; n < NODES; n++) begin : g_inj
      assign inj_v[n] = tx_pull[n] && (sring_q[n] == RING_W'(r));
      assign inj_l[n] = (left_q[n] == BEAT_W'(1));
      assign inj_dst[n*NODE_W +: NODE_W] = sdst_q[n];
    end
    ring_lane #(
      .NODES(NODES), .DATA_W(DATA_W), .NODE_W(NODE_W), .DIR(dir_of(r))
    ) i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .inj_valid (inj_v),
      .inj_last  (inj_l),
      .inj_dst   (inj_dst),
      .inj_data  (tx_data),
      .rx_valid  (rx_valid[r*NODES +: NODES]),
      .rx_last   (rx_last[r*NODES +: NODES]),
      .rx_data   (rx_data[r*NODES*DATA_W +: NODES*DATA_W])
    );
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R2

endmodule

// File: tb/test_ring_fabric_ctl.sv
module test_ring_fabric_ctl;

  localparam int N  = 8;
  localparam int RG = 4;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int NW = 3;
  localparam int RW = 2;

  // src, dst, beats, expected ring, hops
  localparam int VEC [6][5] = '{
    '{0, 3, 2, 0, 3},
    '{0, 5, 1, 1, 3},
    '{2, 6, 3, 0, 4},
    '{6, 1, 2, 0, 3},
    '{1, 7, 4, 1, 2},
    '{5, 4, 1, 1, 1}
  };

  logic                clk = 1'b0;
  logic                rst_n;
  logic [N-1:0]        req_valid;
  logic [N-1:0]        req_ready;
  logic [N*NW-1:0]     req_dst;
  logic [N*BW-1:0]     req_beats;
  logic [N-1:0]        gnt_valid;
  logic [N*RW-1:0]     gnt_ring;
  logic [N-1:0]        tx_pull;
  logic [N*DW-1:0]     tx_data;
  logic [RG*N-1:0]     rx_valid;
  logic [RG*N*DW-1:0]  rx_data;
  logic [RG*N-1:0]     rx_last;
  logic [31:0]         cyc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;

  for (genvar n = 0; n < N; n++) begin : g_src
    assign tx_data[n*DW +: DW] = {8'(n), cyc[23:0]};
  end

  ring_fabric_ctl #(.NODES(N), .RINGS(RG), .DATA_W(DW), .BEAT_W(BW)) i_ring_fabric_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst), .req_beats(req_beats),
    .gnt_valid(gnt_valid), .gnt_ring(gnt_ring), .tx_pull(tx_pull), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(input int t);
    while (int'(cyc) < t) @(negedge clk);
  endtask

  task automatic issue(input int s, input int d, input int b, input int r, output int c);
    @(negedge clk);
    req_dst[s*NW +: NW]   = NW'(d);
    req_beats[s*BW +: BW] = BW'(b);
    req_valid[s]          = 1'b1;
    #1;
    chk(req_ready[s] == 1'b1, "R2", "request accepted", longint'(req_ready[s]), 1);
    c = int'(cyc);
    @(negedge clk);
    req_valid[s] = 1'b0;
    chk(gnt_valid[s] && gnt_ring[s*RW +: RW] == RW'(r), "R4",
        "granted ring", gnt_valid[s] ? longint'(gnt_ring[s*RW +: RW]) : -1, r);
    chk(tx_pull[s] == 1'b1, "R6", "pull after grant", longint'(tx_pull[s]), 1);
  endtask

  task automatic check_data(input int s, input int d, input int b, input int r,
                            input int h, input int c);
    int t0 = c + 2 + h;
    int ix = r * N + d;
    wait_to(t0 - 1);
    chk(rx_valid[ix] == 1'b0, "R7", "no beat before latency", longint'(rx_valid[ix]), 0);
    for (int k = 0; k < b; k++) begin
      wait_to(t0 + k);
      chk(rx_valid[ix] == 1'b1, "R7", "beat valid", longint'(rx_valid[ix]), 1);
      chk(rx_data[ix*DW +: DW] == {8'(s), 24'(c + 1 + k)}, "R7", "beat data",
          longint'(rx_data[ix*DW +: DW]), longint'({8'(s), 24'(c + 1 + k)}));
      chk(rx_last[ix] == (k == b - 1), "R7", "last flag",
          longint'(rx_last[ix]), longint'(k == b - 1));
    end
    wait_to(t0 + b);
    chk(rx_valid[ix] == 1'b0, "R7", "no beat after last", longint'(rx_valid[ix]), 0);
  endtask

  initial begin
    int c, c0;
    rst_n     = 1'b0;
    req_valid = '0;
    req_dst   = '0;
    req_beats = '0;
    repeat (3) @(negedge clk);
    chk(gnt_valid == '0 && tx_pull == '0 && rx_valid == '0, "R1", "outputs in reset",
        longint'(gnt_valid | tx_pull), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == '0 && gnt_valid == '0 && tx_pull == '0 && rx_valid == '0, "R1",
        "outputs after reset", longint'(req_ready | gnt_valid | tx_pull), 0);

    // table walk: single transfers on an idle fabric (R4, R6, R7)
    foreach (VEC[i]) begin
      issue(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], c);
      check_data(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], c);
      repeat (3) @(negedge clk);
    end

    // R10: disjoint spans share ring 0 while both are in flight
    issue(0, 3, 6, 0, c0);
    issue(4, 7, 2, 0, c);
    check_data(4, 7, 2, 0, 3, c);
    repeat (20) @(negedge clk);

    // R4 fallback and R8 release: every ring blocked for 3->4 until ring 0 frees
    issue(0, 4, 3, 0, c0);
    issue(1, 5, 15, 2, c);
    issue(6, 5, 15, 1, c);
    issue(7, 5, 15, 3, c);
    @(negedge clk);
    req_dst[3*NW +: NW]   = 3'd4;
    req_beats[3*BW +: BW] = 4'd1;
    req_valid[3]          = 1'b1;
    #1;
    chk(int'(cyc) == c0 + 8 && req_ready[3] == 1'b0, "R8", "blocked before release",
        longint'(req_ready[3]), 0);
    @(negedge clk);
    chk(req_ready[3] == 1'b1, "R8", "accepted in release cycle", longint'(req_ready[3]), 1);
    @(negedge clk);
    req_valid[3] = 1'b0;
    chk(gnt_valid[3] && gnt_ring[3*RW +: RW] == 2'd0, "R8", "ring after release",
        longint'(gnt_ring[3*RW +: RW]), 0);
    repeat (50) @(negedge clk);

    // R3 round robin: last accepted is node 3
    req_dst[2*NW +: NW] = 3'd3; req_beats[2*BW +: BW] = 4'd1; req_valid[2] = 1'b1;
    req_dst[5*NW +: NW] = 3'd6; req_beats[5*BW +: BW] = 4'd1; req_valid[5] = 1'b1;
    #1;
    chk(req_ready == 8'b0010_0000, "R3", "rr picks node 5 after 3", longint'(req_ready), 32);
    @(negedge clk);
    req_valid[5] = 1'b0;
    #1;
    chk(req_ready == 8'b0000_0100, "R3", "rr then node 2", longint'(req_ready), 4);
    @(negedge clk);
    req_valid[2] = 1'b0;
    repeat (10) @(negedge clk);
    req_dst[1*NW +: NW] = 3'd0; req_beats[1*BW +: BW] = 4'd1; req_valid[1] = 1'b1;
    req_dst[6*NW +: NW] = 3'd7; req_beats[6*BW +: BW] = 4'd1; req_valid[6] = 1'b1;
    #1;
    chk(req_ready == 8'b0100_0000, "R3", "rr picks node 6 after 2", longint'(req_ready), 64);
    @(negedge clk);
    req_valid[6] = 1'b0;
    #1;
    chk(req_ready == 8'b0000_0010, "R3", "rr then node 1", longint'(req_ready), 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    repeat (10) @(negedge clk);

    // R9: zero beats and self destination are never accepted
    req_dst[4*NW +: NW] = 3'd6; req_beats[4*BW +: BW] = 4'd0; req_valid[4] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_ready[4] == 1'b0, "R9", "zero beats refused", longint'(req_ready[4]), 0);
      @(negedge clk);
    end
    req_dst[4*NW +: NW] = 3'd4; req_beats[4*BW +: BW] = 4'd1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_ready[4] == 1'b0, "R9", "self destination refused", longint'(req_ready[4]), 0);
      @(negedge clk);
    end
    req_valid[4] = 1'b0;
    chk(tx_pull == '0 && rx_valid == '0, "R9", "no traffic from refused requests",
        longint'(tx_pull), 0);

    // R9: a streaming node is held off until its last beat is taken
    issue(0, 1, 6, 0, c);
    req_dst[0*NW +: NW] = 3'd2; req_beats[0*BW +: BW] = 4'd1; req_valid[0] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      #1;
      chk(req_ready[0] == 1'b0, "R9", "busy source refused", longint'(req_ready[0]), 0);
      @(negedge clk);
    end
    #1;
    chk(int'(cyc) == c + 7 && req_ready[0] == 1'b1, "R9", "source free again",
        longint'(req_ready[0]), 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1-all watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule